// File: doc/BRIEF.md
# PCI Special-Cycle Message Handler

This block handles broadcast messages on a PCI-style bus in two roles. As a bus master, it runs a single-data-phase transaction on request. When no target claims the transaction, the block ends it by master-abort. A special-cycle broadcast always ends this way. The block keeps the sticky received-master-abort status bit clear for that expected case and sets it for any other command that goes unclaimed.

As a receiving agent, the block watches the bus for a special-cycle address phase. It takes the message and its data on the first clock where the initiator-ready signal is active, and any wait clocks before that are skipped. A masked comparator then decides whether the message concerns this agent. When it does, the block raises a one-clock valid pulse and loads the captured fields. The receiver never claims the cycle, so the block has no device-select output.

Top module: `pci_sc_handler`

## Requirements
- R1: While reset is active and on the first clock after it, the bus drive enable is low, FRAME# and IRDY# outputs are high, the received-master-abort bit is 0, and the message-valid pulse is 0.
- R2: A master transaction starts one clock after `mstStart` is sampled while idle. The address phase is one clock with FRAME# asserted, C/BE# equal to the requested command and AD equal to the requested address. `mstWaits` clocks follow, with FRAME# low and IRDY# high. Then the data phase begins with FRAME# deasserted on the same clock that IRDY# is first asserted.
- R3: If DEVSEL# is not sampled low during the data phase, IRDY# stays asserted for exactly ABORT_CLKS clocks. It is then released, and the bus drive enable drops exactly one clock after that release.
- R4: A master-abort that ends a special cycle (C/BE# = 4'b0001 in the address phase) leaves the received-master-abort bit unchanged.
- R5: A master-abort that ends any other command sets the received-master-abort bit. The bit stays set until reset.
- R6: If DEVSEL# is sampled low on a data-phase clock, the transfer ends on that clock, so IRDY# has been asserted for exactly the clocks up to and including it, and the status bit is not changed.
- R7: The receiver treats the first clock of FRAME# low after FRAME# was high as an address phase. It arms only when C/BE# equals 4'b0001 there. Any other command produces no message-valid pulse.
- R8: Once armed, the receiver captures on the first clock with IRDY# low, taking the message from AD[15:0] and the message data from AD[31:16]. AD values during the wait clocks and during later data clocks are ignored.
- R9: `msgValid` pulses for exactly one clock, on the clock after the capture. It pulses only when (message & MSG_MASK) equals (MSG_MATCH & MSG_MASK); the defaults are mask 16'hFF00 and match 16'h1200. `msgCode` and `msgData` change only on an applicable message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mstStart | input | 1 | Request a master transaction (sampled when idle) |
| mstCmd | input | 4 | Command for the master transaction |
| mstAddr | input | 32 | Address for the address phase |
| mstData | input | 32 | Data word for the data phase |
| mstWaits | input | 2 | Wait clocks between the address phase and the first IRDY# clock |
| mstBusy | output | 1 | Master transaction in progress |
| frameInN | input | 1 | FRAME# as seen on the bus |
| irdyInN | input | 1 | IRDY# as seen on the bus |
| devselInN | input | 1 | DEVSEL# as seen on the bus |
| cbeInN | input | 4 | C/BE# as seen on the bus |
| adIn | input | 32 | AD as seen on the bus |
| busOe | output | 1 | Enables the block's drivers for FRAME#, IRDY#, C/BE# and AD |
| frameOutN | output | 1 | FRAME# driven value |
| irdyOutN | output | 1 | IRDY# driven value |
| cbeOutN | output | 4 | C/BE# driven value |
| adOut | output | 32 | AD driven value |
| rcvMasterAbort | output | 1 | Sticky received-master-abort status bit |
| msgValid | output | 1 | One-clock pulse for an applicable broadcast message |
| msgCode | output | 16 | Last applicable message |
| msgData | output | 16 | Data of the last applicable message |

## Verification
The bench varies the number of wait clocks. It also puts a decoy word on AD during the wait clocks and during the data clock after the first one. A receiver that captured on the wrong clock would report the decoy instead of the real message. An unclaimed special cycle is run next to an unclaimed ordinary command. A design that did not tell the two apart would either set the status bit on every broadcast or never set it at all.

The bench also sends a message that matches the comparator but carries a non-broadcast command, and a broadcast whose upper byte does not match. A loose decoder would pulse on either of them. The bench counts the IRDY# clocks and the release clock, so an abort that ends one clock early or late, or that drops the drivers together with IRDY#, is reported.

// File: rtl/pci_sc_pkg.sv
package pci_sc_pkg;

  localparam logic [3:0] CMD_SPECIAL = 4'b0001;

  typedef enum logic [2:0] {
    M_IDLE,
    M_ADDR,
    M_WAIT,
    M_DATA,
    M_TURN
  } mst_state_e;

  typedef enum logic {
    R_IDLE,
    R_ARM
  } rx_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic busOe;
    logic frameAct;
    logic irdyAct;
    logic selData;
    logic abortEnd;
    logic rxCap;
  } ctl_strobe_t;

endpackage

// File: rtl/pci_sc_ctrl.sv
module pci_sc_ctrl
  import pci_sc_pkg::*;
#(
  parameter int ABORT_CLKS = 4,
  parameter int WAIT_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mstStart,
  input  logic [WAIT_W-1:0] mstWaits,
  input  logic              frameInN,
  input  logic              irdyInN,
  input  logic              devselInN,
  input  logic [3:0]        cbeInN,
  output ctl_strobe_t       ctl,
  output logic              busy
);

  localparam int TMR_W = $clog2(ABORT_CLKS + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(ABORT_CLKS - 1);

  mst_state_e mState, mNext;
  rx_state_e  rState, rNext;
  logic [WAIT_W-1:0] waitCtr;
  logic [TMR_W-1:0]  abortTmr;
  logic              prevFrameN;
  logic              addrPhase;
  logic              timeout;

  assign timeout   = devselInN && (abortTmr == TMR_LAST);
  assign addrPhase = !frameInN && prevFrameN;
  assign busy      = (mState != M_IDLE);

  always_comb begin
    mNext = mState;
    unique case (mState)
      M_IDLE: if (mstStart) mNext = M_ADDR;
      M_ADDR: mNext = (waitCtr == '0) ? M_DATA : M_WAIT;
      M_WAIT: if (waitCtr == WAIT_W'(1)) mNext = M_DATA;
      M_DATA: if (!devselInN || timeout) mNext = M_TURN;
      M_TURN: mNext = M_IDLE;
      default: mNext = M_IDLE;
    endcase
  end

  always_comb begin
    rNext = rState;
    unique case (rState)
      R_IDLE: if (addrPhase && cbeInN == CMD_SPECIAL) rNext = R_ARM;
      R_ARM:  if (!irdyInN || frameInN) rNext = R_IDLE;
      default: rNext = R_IDLE;
    endcase
  end

  always_comb begin
    ctl = '0;
    unique case (mState)
      M_IDLE: ctl.latchReq = mstStart;
      M_ADDR: begin
        ctl.busOe    = 1'b1;
        ctl.frameAct = 1'b1;
      end
      M_WAIT: begin
        ctl.busOe    = 1'b1;
        ctl.frameAct = 1'b1;
        ctl.selData  = 1'b1;
      end
      M_DATA: begin
        ctl.busOe    = 1'b1;
        ctl.irdyAct  = 1'b1;
        ctl.selData  = 1'b1;
        ctl.abortEnd = timeout;
      end
      M_TURN: ctl.busOe = 1'b1;
      default: ctl = '0;
    endcase
    ctl.rxCap = (rState == R_ARM) && !irdyInN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState     <= M_IDLE;
      rState     <= R_IDLE;
      waitCtr    <= '0;
      abortTmr   <= '0;
      prevFrameN <= 1'b1;
    end else begin
      mState     <= mNext;
      rState     <= rNext;
      prevFrameN <= frameInN;
      if (mState == M_IDLE && mstStart) waitCtr <= mstWaits;
      else if (mState == M_WAIT)        waitCtr <= waitCtr - WAIT_W'(1);
      if (mState == M_DATA) abortTmr <= abortTmr + TMR_W'(1);
      else                  abortTmr <= '0;
    end
  end

endmodule

// File: rtl/pci_sc_datapath.sv
module pci_sc_datapath
  import pci_sc_pkg::*;
#(
  parameter int          AD_W      = 32,
  parameter logic [15:0] MSG_MATCH = 16'h1200,
  parameter logic [15:0] MSG_MASK  = 16'hFF00
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_strobe_t     ctl,
  input  logic [3:0]      mstCmd,
  input  logic [AD_W-1:0] mstAddr,
  input  logic [AD_W-1:0] mstData,
  input  logic [AD_W-1:0] adIn,
  output logic            busOe,
  output logic            frameOutN,
  output logic            irdyOutN,
  output logic [3:0]      cbeOutN,
  output logic [AD_W-1:0] adOut,
  output logic [3:0]      curCmd,
  output logic            rcvMasterAbort,
  output logic            msgValid,
  output logic [15:0]     msgCode,
  output logic [15:0]     msgData
);

  localparam int HALF_W = AD_W / 2;

  logic [3:0]      cmdReg;
  logic [AD_W-1:0] addrReg, dataReg;
  logic            msgApplies;

  assign busOe     = ctl.busOe;
  assign frameOutN = !ctl.frameAct;
  assign irdyOutN  = !ctl.irdyAct;
  assign adOut     = ctl.selData ? dataReg : addrReg;
  assign cbeOutN   = ctl.selData ? 4'b0000 : cmdReg;
  assign curCmd    = cmdReg;

  assign msgApplies = (((adIn[15:0] ^ MSG_MATCH) & MSG_MASK) == 16'h0000);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg         <= '0;
      addrReg        <= '0;
      dataReg        <= '0;
      rcvMasterAbort <= 1'b0;
      msgValid       <= 1'b0;
      msgCode        <= '0;
      msgData        <= '0;
    end else begin
      if (ctl.latchReq) begin
        cmdReg  <= mstCmd;
        addrReg <= mstAddr;
        dataReg <= mstData;
      end
      if (ctl.abortEnd && cmdReg != CMD_SPECIAL) rcvMasterAbort <= 1'b1;
      msgValid <= ctl.rxCap && msgApplies;
      if (ctl.rxCap && msgApplies) begin
        msgCode <= adIn[15:0];
        msgData <= adIn[HALF_W+15:HALF_W];
      end
    end
  end

endmodule

// File: rtl/pci_sc_handler.sv
module pci_sc_handler
  import pci_sc_pkg::*;
#(
  parameter int          ABORT_CLKS = 4,
  parameter int          WAIT_W     = 2,
  parameter logic [15:0] MSG_MATCH  = 16'h1200,
  parameter logic [15:0] MSG_MASK   = 16'hFF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mstStart,
  input  logic [3:0]        mstCmd,
  input  logic [31:0]       mstAddr,
  input  logic [31:0]       mstData,
  input  logic [WAIT_W-1:0] mstWaits,
  output logic              mstBusy,
  input  logic              frameInN,
  input  logic              irdyInN,
  input  logic              devselInN,
  input  logic [3:0]        cbeInN,
  input  logic [31:0]       adIn,
  output logic              busOe,
  output logic              frameOutN,
  output logic              irdyOutN,
  output logic [3:0]        cbeOutN,
  output logic [31:0]       adOut,
  output logic              rcvMasterAbort,
  output logic              msgValid,
  output logic [15:0]       msgCode,
  output logic [15:0]       msgData
);

  ctl_strobe_t ctl;
  logic [3:0]  curCmd;

  pci_sc_ctrl #(.ABORT_CLKS(ABORT_CLKS), .WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mstStart(mstStart), .mstWaits(mstWaits),
    .frameInN(frameInN), .irdyInN(irdyInN), .devselInN(devselInN),
    .cbeInN(cbeInN), .ctl(ctl), .busy(mstBusy)
  );

  pci_sc_datapath #(.AD_W(32), .MSG_MATCH(MSG_MATCH), .MSG_MASK(MSG_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mstCmd(mstCmd), .mstAddr(mstAddr),
    .mstData(mstData), .adIn(adIn), .busOe(busOe), .frameOutN(frameOutN),
    .irdyOutN(irdyOutN), .cbeOutN(cbeOutN), .adOut(adOut), .curCmd(curCmd),
    .rcvMasterAbort(rcvMasterAbort), .msgValid(msgValid),
    .msgCode(msgCode), .msgData(msgData)
  );

endmodule

// File: rtl/pci_sc_chk.sv
module pci_sc_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busOe,
  input logic       frameOutN,
  input logic       irdyOutN,
  input logic       devselInN,
  input logic [3:0] curCmd,
  input logic       rcvMasterAbort,
  input logic       msgValid
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!busOe && !rcvMasterAbort && !msgValid));

  // R2
  frame_with_irdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && $fell(irdyOutN)) |-> frameOutN);

  // R3
  release_after_irdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && $rose(irdyOutN)) |=> !busOe);

  // R4
  special_no_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rcvMasterAbort) |-> ($past(curCmd) != 4'b0001));

  // R5
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rcvMasterAbort |=> rcvMasterAbort);

  // R6
  claimed_no_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && !irdyOutN && !devselInN) |=> $stable(rcvMasterAbort));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |=> !msgValid);

endmodule

bind pci_sc_handler pci_sc_chk u_chk (
  .clk(clk), .rstN(rstN), .busOe(busOe), .frameOutN(frameOutN),
  .irdyOutN(irdyOutN), .devselInN(devselInN), .curCmd(curCmd),
  .rcvMasterAbort(rcvMasterAbort), .msgValid(msgValid)
);

// File: tb/sim_pci_sc_handler.sv
module sim_pci_sc_handler;

  localparam int          ABORT_CLKS = 4;
  localparam logic [15:0] MATCH      = 16'h1200;
  localparam logic [15:0] MASK       = 16'hFF00;
  localparam logic [3:0]  SPC        = 4'b0001;
  localparam int          NVEC       = 6;

  // {cmd[38:35], waits[34:33], ad[32:1], expectValid[0]}
  localparam logic [38:0] VEC [NVEC] = '{
    {4'b0001, 2'd0, 32'hBEEF_1234, 1'b1},
    {4'b0001, 2'd2, 32'h0001_12AB, 1'b1},
    {4'b0001, 2'd1, 32'h5555_3412, 1'b0},
    {4'b0110, 2'd0, 32'hCAFE_1299, 1'b0},
    {4'b0001, 2'd3, 32'h0000_12FF, 1'b1},
    {4'b1011, 2'd0, 32'h1111_1200, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mstStart = 1'b0;
  logic [3:0] mstCmd = '0;
  logic [31:0] mstAddr = '0, mstData = '0;
  logic [1:0] mstWaits = '0;
  logic mstBusy;
  logic tbFrameN = 1'b1, tbIrdyN = 1'b1, devDrvN = 1'b1;
  logic [3:0] tbCbeN = 4'hF;
  logic [31:0] tbAd = '0;
  logic busOe, frameOutN, irdyOutN, rcvMasterAbort, msgValid;
  logic [3:0] cbeOutN;
  logic [31:0] adOut;
  logic [15:0] msgCode, msgData;

  logic frameInN, irdyInN;
  logic [3:0] cbeInN;
  logic [31:0] adIn;
  assign frameInN = busOe ? frameOutN : tbFrameN;
  assign irdyInN  = busOe ? irdyOutN  : tbIrdyN;
  assign cbeInN   = busOe ? cbeOutN   : tbCbeN;
  assign adIn     = busOe ? adOut     : tbAd;

  int checks = 0;
  int errors = 0;
  logic [15:0] lastCode = '0, lastData = '0;

  always #2 clk = ~clk;

  pci_sc_handler #(.ABORT_CLKS(ABORT_CLKS), .WAIT_W(2), .MSG_MATCH(MATCH), .MSG_MASK(MASK)) u0 (
    .clk(clk), .rstN(rstN), .mstStart(mstStart), .mstCmd(mstCmd),
    .mstAddr(mstAddr), .mstData(mstData), .mstWaits(mstWaits), .mstBusy(mstBusy),
    .frameInN(frameInN), .irdyInN(irdyInN), .devselInN(devDrvN), .cbeInN(cbeInN),
    .adIn(adIn), .busOe(busOe), .frameOutN(frameOutN), .irdyOutN(irdyOutN),
    .cbeOutN(cbeOutN), .adOut(adOut), .rcvMasterAbort(rcvMasterAbort),
    .msgValid(msgValid), .msgCode(msgCode), .msgData(msgData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // receive-side transfer driven by the bench
  task automatic rxXfer(input logic [3:0] cmd, input logic [1:0] w,
                        input logic [31:0] ad, input logic exp);
    @(negedge clk);
    tbFrameN = 1'b0; tbIrdyN = 1'b1; tbCbeN = cmd; tbAd = 32'hA5A5_A5A5;
    for (int k = 0; k < int'(w); k++) begin
      @(negedge clk);
      tbCbeN = 4'h0; tbAd = ~ad;
    end
    @(negedge clk);
    tbIrdyN = 1'b0; tbCbeN = 4'h0; tbAd = ad;
    @(negedge clk);
    if (exp) begin lastCode = ad[15:0]; lastData = ad[31:16]; end
    chk("R9 msgValid after capture", {31'd0, msgValid}, {31'd0, exp});
    chk("R8 captured message and data", {msgData, msgCode}, {lastData, lastCode});
    tbFrameN = 1'b1; tbAd = ~ad ^ 32'h0000_0F0F;
    @(negedge clk);
    chk("R9 pulse lasts one clock", {31'd0, msgValid}, 32'd0);
    chk("R8 later data clock ignored", {msgData, msgCode}, {lastData, lastCode});
    tbIrdyN = 1'b1; tbCbeN = 4'hF;
    @(negedge clk);
  endtask

  task automatic mstRun(input logic [3:0] cmd, input logic [1:0] w,
                        input logic [31:0] a, input logic [31:0] d, input int devAt,
                        output int irdyCnt, output int turnCnt, output logic frameAtIrdy,
                        output logic [3:0] cbeA, output logic [31:0] adA, output logic sawMsg);
    logic seenAddr;
    @(negedge clk);
    mstCmd = cmd; mstWaits = w; mstAddr = a; mstData = d; mstStart = 1'b1;
    irdyCnt = 0; turnCnt = 0; seenAddr = 1'b0; sawMsg = 1'b0;
    frameAtIrdy = 1'b0; cbeA = '0; adA = '0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      mstStart = 1'b0; devDrvN = 1'b1;
      if (msgValid) sawMsg = 1'b1;
      if (busOe && !frameOutN && !seenAddr) begin
        seenAddr = 1'b1; cbeA = cbeOutN; adA = adOut;
      end
      if (busOe && !irdyOutN) begin
        irdyCnt++;
        if (irdyCnt == 1) frameAtIrdy = frameOutN;
        if (devAt != 0 && irdyCnt == devAt) devDrvN = 1'b0;
      end
      if (busOe && irdyOutN && frameOutN) turnCnt++;
      if (!mstBusy) break;
    end
    devDrvN = 1'b1;
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ic, tc;
    logic fi, sm;
    logic [3:0] cb;
    logic [31:0] aa;

    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 reset oe/frame/irdy", {29'd0, busOe, frameOutN, irdyOutN}, {29'd0, 1'b0, 1'b1, 1'b1});
    chk("R1 reset status/valid", {30'd0, rcvMasterAbort, msgValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 first clock after reset", {30'd0, busOe, msgValid}, 32'd0);

    // receive-side vector table (R7, R8, R9)
    for (int i = 0; i < NVEC; i++)
      rxXfer(VEC[i][38:35], VEC[i][34:33], VEC[i][32:1], VEC[i][0]);

    // R7 non-special command that would match was ignored (vector 4)
    chk("R7 message kept from last special cycle", {16'd0, msgCode}, {16'd0, 16'h12FF});

    // special cycle, unclaimed
    mstRun(SPC, 2'd1, 32'h0000_0000, 32'h00AA_12C3, 0, ic, tc, fi, cb, aa, sm);
    chk("R2 address phase command", {28'd0, cb}, {28'd0, SPC});
    chk("R2 address phase AD", aa, 32'h0000_0000);
    chk("R2 frame deasserted with first irdy", {31'd0, fi}, 32'd1);
    chk("R3 irdy clocks on abort", ic, ABORT_CLKS);
    chk("R3 one release clock", tc, 1);
    chk("R3 bus released after", {31'd0, busOe}, 32'd0);
    chk("R4 special abort leaves status clear", {31'd0, rcvMasterAbort}, 32'd0);
    chk("R8 loopback message seen", {31'd0, sm}, 32'd1);
    chk("R9 loopback code/data", {msgData, msgCode}, 32'h00AA_12C3);

    // claimed ordinary command
    mstRun(4'b0111, 2'd0, 32'h1000_0040, 32'h1234_5678, 2, ic, tc, fi, cb, aa, sm);
    chk("R2 command of ordinary write", {28'd0, cb}, 32'h7);
    chk("R6 transfer ends on devsel", ic, 2);
    chk("R6 status unchanged when claimed", {31'd0, rcvMasterAbort}, 32'd0);

    // unclaimed ordinary command
    mstRun(4'b0110, 2'd2, 32'h2000_0000, 32'h0000_12AA, 0, ic, tc, fi, cb, aa, sm);
    chk("R3 irdy clocks on ordinary abort", ic, ABORT_CLKS);
    chk("R5 ordinary abort sets status", {31'd0, rcvMasterAbort}, 32'd1);
    chk("R7 ordinary command gives no message", {31'd0, sm}, 32'd0);

    // status stays set across a later special cycle
    mstRun(SPC, 2'd0, 32'h0, 32'h0000_3400, 0, ic, tc, fi, cb, aa, sm);
    chk("R5 status sticky", {31'd0, rcvMasterAbort}, 32'd1);
    chk("R9 non-applicable loopback ignored", {31'd0, sm}, 32'd0);

    // reset clears status
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset clears status", {31'd0, rcvMasterAbort}, 32'd0);
    chk("R1 reset clears message", {msgData, msgCode}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule